// File: doc/BRIEF.md
# Branch and Jump Next-PC Unit

This block decides where the program counter goes after each instruction of a 32-bit RISC-V integer core. It takes the current PC, the instruction word and the two source register values. It returns the next PC, a flag that is high when control flow leaves the sequential path, the return-address value, and a write enable for that value. All six conditional-branch conditions are evaluated, including the two unsigned forms. The B-type and J-type immediates are reassembled from their scattered bit positions and sign-extended. The indirect-jump target has its lowest bit cleared.

The unit is purely combinational, so there is no stream on its edge and no valid/ready handshake. It sits between decode and fetch. The caller presents a new instruction whenever it likes and reads the results in the same cycle. Any opcode that is not a branch or a jump advances the PC by 4.

Top module: `nextpc_unit`

## Requirements
- R1: With opcode 1100011, funct3 000 is taken when rs1 equals rs2 and funct3 001 is taken when they differ. A taken branch sets next_pc to pc plus the B immediate. An untaken branch sets next_pc to pc+4.
- R2: With opcode 1100011, funct3 100 is taken when rs1 < rs2 and funct3 101 is taken when rs1 >= rs2, both comparing two's-complement signed values.
- R3: With opcode 1100011, funct3 110 is taken when rs1 < rs2 and funct3 111 is taken when rs1 >= rs2, both comparing unsigned values.
- R4: With opcode 1100011, funct3 010 and 011 are never taken: taken_o is 0 and next_pc is pc+4.
- R5: The B immediate is {inst[31], inst[7], inst[30:25], inst[11:8], 0}, sign-extended from bit 12. This allows backward offsets down to -4096.
- R6: Opcode 1101111 is always taken, with next_pc = pc + {inst[31], inst[19:12], inst[20], inst[30:21], 0}, sign-extended from bit 20.
- R7: Opcode 1100111 is always taken, with next_pc = (rs1 + inst[31:20] sign-extended) with bit 0 forced to 0.
- R8: link_val_o always equals pc+4. link_we_o is 1 only for opcodes 1101111 and 1100111 with rd = inst[11:7] not zero.
- R9: For every other opcode, taken_o is 0, link_we_o is 0 and next_pc is pc+4, whatever the operand values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pc_i | input | 32 | Address of the current instruction |
| inst_i | input | 32 | Instruction word |
| rs1_val_i | input | 32 | First source register value |
| rs2_val_i | input | 32 | Second source register value |
| next_pc_o | output | 32 | Address of the next instruction |
| taken_o | output | 1 | Control flow leaves the sequential path |
| link_val_o | output | 32 | Return address (pc+4) |
| link_we_o | output | 1 | Write link_val_o to register rd |

## Verification
Every output is a combinational function of the current inputs, so each result is due zero cycles after a stimulus. The bench applies a new instruction and operand set just after a rising clock edge. It compares all four outputs at the following falling edge, when the logic has settled and no edge is being processed. Each vector is judged only against its own inputs, and no state is carried from one vector to the next.

// File: rtl/nextpc_pkg.sv
package nextpc_pkg;
  localparam logic [6:0] OPC_BRANCH = 7'b1100011;
  localparam logic [6:0] OPC_JAL    = 7'b1101111;
  localparam logic [6:0] OPC_JALR   = 7'b1100111;

  typedef enum logic [2:0] {
    CND_EQ   = 3'b000,
    CND_NE   = 3'b001,
    CND_RSV2 = 3'b010,
    CND_RSV3 = 3'b011,
    CND_LT   = 3'b100,
    CND_GE   = 3'b101,
    CND_LTU  = 3'b110,
    CND_GEU  = 3'b111
  } cond_e;

  typedef enum logic [1:0] {
    FK_SEQ,
    FK_BRANCH,
    FK_JAL,
    FK_JALR
  } flow_kind_e;

  typedef struct packed {
    logic eq;
    logic lt;
    logic ltu;
  } cmp_flags_t;
endpackage

// File: rtl/nextpc_imm.sv
module nextpc_imm #(
  parameter int XLEN = 32
) (
  input  logic [31:7]     inst_hi,
  output logic [XLEN-1:0] imm_b,
  output logic [XLEN-1:0] imm_j,
  output logic [XLEN-1:0] imm_i
);
  localparam int BW = 13;
  localparam int JW = 21;
  localparam int IW = 12;

  logic [BW-1:0] raw_b;
  logic [JW-1:0] raw_j;
  logic [IW-1:0] raw_i;

  assign raw_b = {inst_hi[31], inst_hi[7], inst_hi[30:25], inst_hi[11:8], 1'b0};
  assign raw_j = {inst_hi[31], inst_hi[19:12], inst_hi[20], inst_hi[30:21], 1'b0};
  assign raw_i = inst_hi[31:20];

  assign imm_b = {{(XLEN-BW){raw_b[BW-1]}}, raw_b};
  assign imm_j = {{(XLEN-JW){raw_j[JW-1]}}, raw_j};
  assign imm_i = {{(XLEN-IW){raw_i[IW-1]}}, raw_i};
endmodule

// File: rtl/nextpc_cmp.sv
module nextpc_cmp
  import nextpc_pkg::*;
#(
  parameter int XLEN       = 32,
  parameter bit SHARED_SUB = 1'b1
) (
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  output cmp_flags_t      flags
);
  localparam int MSB = XLEN - 1;

  assign flags.eq = (a == b);

  generate
    if (SHARED_SUB) begin : g_sub
      logic [XLEN:0] diff;
      assign diff = {1'b0, a} - {1'b0, b};
      assign flags.ltu = diff[XLEN];
      assign flags.lt  = (a[MSB] ^ b[MSB]) ? a[MSB] : diff[XLEN];
    end else begin : g_direct
      assign flags.ltu = (a < b);
      assign flags.lt  = ($signed(a) < $signed(b));
    end
  endgenerate
endmodule

// File: rtl/nextpc_unit.sv
module nextpc_unit
  import nextpc_pkg::*;
#(
  parameter int XLEN       = 32,
  parameter bit SHARED_SUB = 1'b1
) (
  input  logic [XLEN-1:0] pc_i,
  input  logic [31:0]     inst_i,
  input  logic [XLEN-1:0] rs1_val_i,
  input  logic [XLEN-1:0] rs2_val_i,
  output logic [XLEN-1:0] next_pc_o,
  output logic            taken_o,
  output logic [XLEN-1:0] link_val_o,
  output logic            link_we_o
);
  localparam logic [XLEN-1:0] STEP = XLEN'(4);

  flow_kind_e      kind;
  cond_e           cond;
  cmp_flags_t      flags;
  logic            cond_true;
  logic [XLEN-1:0] imm_b, imm_j, imm_i;
  logic [XLEN-1:0] base, offs, sum, target, pc_plus4;

  always_comb begin
    unique case (inst_i[6:0])
      OPC_BRANCH: kind = FK_BRANCH;
      OPC_JAL:    kind = FK_JAL;
      OPC_JALR:   kind = FK_JALR;
      default:    kind = FK_SEQ;
    endcase
  end

  assign cond = cond_e'(inst_i[14:12]);

  nextpc_imm #(.XLEN(XLEN)) u_imm (
    .inst_hi (inst_i[31:7]),
    .imm_b   (imm_b),
    .imm_j   (imm_j),
    .imm_i   (imm_i)
  );

  nextpc_cmp #(.XLEN(XLEN), .SHARED_SUB(SHARED_SUB)) u_cmp (
    .a     (rs1_val_i),
    .b     (rs2_val_i),
    .flags (flags)
  );

  always_comb begin
    unique case (cond)
      CND_EQ:  cond_true = flags.eq;
      CND_NE:  cond_true = !flags.eq;
      CND_LT:  cond_true = flags.lt;
      CND_GE:  cond_true = !flags.lt;
      CND_LTU: cond_true = flags.ltu;
      CND_GEU: cond_true = !flags.ltu;
      default: cond_true = 1'b0;
    endcase
  end

  // One adder serves all three target forms
  always_comb begin
    base = pc_i;
    offs = imm_b;
    unique case (kind)
      FK_JAL:  offs = imm_j;
      FK_JALR: begin
        base = rs1_val_i;
        offs = imm_i;
      end
      default: offs = imm_b;
    endcase
  end

  assign sum      = base + offs;
  assign target   = (kind == FK_JALR) ? {sum[XLEN-1:1], 1'b0} : sum;
  assign pc_plus4 = pc_i + STEP;

  always_comb begin
    unique case (kind)
      FK_JAL, FK_JALR: taken_o = 1'b1;
      FK_BRANCH:       taken_o = cond_true;
      default:         taken_o = 1'b0;
    endcase
  end

  assign next_pc_o  = taken_o ? target : pc_plus4;
  assign link_val_o = pc_plus4;
  assign link_we_o  = ((kind == FK_JAL) || (kind == FK_JALR)) && (inst_i[11:7] != 5'd0);
endmodule

// File: rtl/nextpc_unit_chk.sv
module nextpc_unit_chk
  import nextpc_pkg::*;
#(
  parameter int XLEN = 32
) (
  input logic [6:0]      opc,
  input logic [2:0]      f3,
  input logic [4:0]      rd,
  input logic [XLEN-1:0] rs1_val,
  input logic [XLEN-1:0] rs2_val,
  input logic [XLEN-1:0] next_pc,
  input logic            taken,
  input logic [XLEN-1:0] link_val,
  input logic            link_we
);
  logic is_jump, is_br;
  assign is_jump = (opc == OPC_JAL) || (opc == OPC_JALR);
  assign is_br   = (opc == OPC_BRANCH);

  always_comb begin
    AST_FALLTHRU_PC4: assert (taken || (next_pc == link_val)) else $error("fallthrough"); // R1
    AST_EQ_COND: assert (!(is_br && f3 == 3'b000) || (taken == (rs1_val == rs2_val))) else $error("beq"); // R1
    AST_RSV_NOT_TAKEN: assert (!(is_br && f3[2:1] == 2'b01) || !taken) else $error("reserved"); // R4
    AST_JALR_EVEN: assert (!(opc == OPC_JALR) || (next_pc[0] == 1'b0)) else $error("jalr lsb"); // R7
    AST_LINK_WE_RULE: assert (link_we == (is_jump && rd != 5'd0)) else $error("link we"); // R8
    AST_SEQ_IDLE: assert (is_jump || is_br || (!taken && !link_we)) else $error("seq"); // R9
  end
endmodule

bind nextpc_unit nextpc_unit_chk #(.XLEN(XLEN)) u_chk (
  .opc      (inst_i[6:0]),
  .f3       (inst_i[14:12]),
  .rd       (inst_i[11:7]),
  .rs1_val  (rs1_val_i),
  .rs2_val  (rs2_val_i),
  .next_pc  (next_pc_o),
  .taken    (taken_o),
  .link_val (link_val_o),
  .link_we  (link_we_o)
);

// File: tb/nextpc_unit_tb.sv
`timescale 1ns/1ps
module nextpc_unit_tb;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic [31:0] pc, inst, a, b, npc, link;
  logic        taken, we;
  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  nextpc_unit u_dut (
    .pc_i(pc), .inst_i(inst), .rs1_val_i(a), .rs2_val_i(b),
    .next_pc_o(npc), .taken_o(taken), .link_val_o(link), .link_we_o(we)
  );

  function automatic logic [31:0] mk_b(input logic [12:0] off, input logic [2:0] f3,
                                      input logic [4:0] s1, input logic [4:0] s2);
    return {off[12], off[10:5], s2, s1, f3, off[4:1], off[11], 7'b1100011};
  endfunction

  function automatic logic [31:0] mk_j(input logic [20:0] off, input logic [4:0] rd);
    return {off[20], off[10:1], off[11], off[19:12], rd, 7'b1101111};
  endfunction

  function automatic logic [31:0] mk_jr(input logic [11:0] off, input logic [4:0] rd);
    return {off, 5'd1, 3'b000, rd, 7'b1100111};
  endfunction

  function automatic string tag_of(input logic [31:0] w);
    if (w[6:0] == 7'b1101111) return "R6";
    if (w[6:0] == 7'b1100111) return "R7";
    if (w[6:0] != 7'b1100011) return "R9";
    case (w[14:12])
      3'b000, 3'b001: return "R1";
      3'b100, 3'b101: return "R2";
      3'b110, 3'b111: return "R3";
      default:        return "R4";
    endcase
  endfunction

  task automatic ref_model(output logic [31:0] e_npc, output logic e_tk, output logic e_we);
    logic [31:0] ob, oj, oi, t;
    logic c;
    ob = {{19{inst[31]}}, inst[31], inst[7], inst[30:25], inst[11:8], 1'b0};
    oj = {{11{inst[31]}}, inst[31], inst[19:12], inst[20], inst[30:21], 1'b0};
    oi = {{20{inst[31]}}, inst[31:20]};
    e_tk = 1'b0; e_we = 1'b0; t = pc + 32'd4;
    case (inst[6:0])
      7'b1100011: begin
        case (inst[14:12])
          3'b000: c = (a == b);
          3'b001: c = (a != b);
          3'b100: c = ($signed(a) < $signed(b));
          3'b101: c = ($signed(a) >= $signed(b));
          3'b110: c = (a < b);
          3'b111: c = (a >= b);
          default: c = 1'b0;
        endcase
        e_tk = c;
        if (c) t = pc + ob;
      end
      7'b1101111: begin e_tk = 1; e_we = (inst[11:7] != 0); t = pc + oj; end
      7'b1100111: begin e_tk = 1; e_we = (inst[11:7] != 0); t = (a + oi) & ~32'd1; end
      default: ;
    endcase
    e_npc = t;
  endtask

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h (inst %h)", tag, what, act, exp, inst);
    end
  endtask

  task automatic apply(input logic [31:0] p, input logic [31:0] w, input logic [31:0] x, input logic [31:0] y);
    logic [31:0] e_npc;
    logic e_tk, e_we;
    @(posedge clk);
    #1;
    pc = p; inst = w; a = x; b = y;
    @(negedge clk);
    ref_model(e_npc, e_tk, e_we);
    chk(tag_of(w), "next_pc", npc, e_npc);
    chk(tag_of(w), "taken", {31'd0, taken}, {31'd0, e_tk});
    chk("R8", "link_val", link, p + 32'd4);
    chk("R8", "link_we", {31'd0, we}, {31'd0, e_we});
  endtask

  task automatic expect_pc(input string tag, input logic [31:0] e);
    chk(tag, "directed next_pc", npc, e);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_fail++;
      n_tests++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    pc = 0; inst = 32'h00000013; a = 0; b = 0;
    @(negedge clk);
    chk("R9", "initial next_pc", npc, 32'd4);
    chk("R9", "initial taken", {31'd0, taken}, 32'd0);

    // R1 equal / not equal
    apply(32'h1000, mk_b(13'd16, 3'b000, 5'd1, 5'd2), 32'h55, 32'h55);
    expect_pc("R1", 32'h1010);
    apply(32'h1000, mk_b(13'd16, 3'b001, 5'd1, 5'd2), 32'h55, 32'h55);
    expect_pc("R1", 32'h1004);
    // R2 signed: -1 < 1
    apply(32'h2000, mk_b(13'd8, 3'b100, 5'd1, 5'd2), 32'hFFFF_FFFF, 32'd1);
    expect_pc("R2", 32'h2008);
    apply(32'h2000, mk_b(13'd8, 3'b101, 5'd1, 5'd2), 32'h8000_0000, 32'h7FFF_FFFF);
    expect_pc("R2", 32'h2004);
    // R3 unsigned: 0xFFFFFFFF not below 1
    apply(32'h3000, mk_b(13'd8, 3'b110, 5'd1, 5'd2), 32'hFFFF_FFFF, 32'd1);
    expect_pc("R3", 32'h3004);
    apply(32'h3000, mk_b(13'd8, 3'b111, 5'd1, 5'd2), 32'h5, 32'h5);
    expect_pc("R3", 32'h3008);
    // R4 reserved conditions
    apply(32'h4000, mk_b(13'd8, 3'b010, 5'd1, 5'd2), 32'h0, 32'h0);
    expect_pc("R4", 32'h4004);
    apply(32'h4000, mk_b(13'd8, 3'b011, 5'd1, 5'd2), 32'h0, 32'h1);
    expect_pc("R4", 32'h4004);
    // R5 most negative branch offset and bit 11 placement
    apply(32'h5000, mk_b(13'h1000, 3'b000, 5'd1, 5'd2), 32'h0, 32'h0);
    expect_pc("R5", 32'h4000);
    apply(32'h5000, mk_b(13'h0800, 3'b000, 5'd1, 5'd2), 32'h0, 32'h0);
    expect_pc("R5", 32'h5800);
    // R6 JAL extremes
    apply(32'h0020_0000, mk_j(21'h100000, 5'd1), 32'h0, 32'h0);
    expect_pc("R6", 32'h0010_0000);
    apply(32'h0000_1000, mk_j(21'h0FFFFE, 5'd0), 32'h0, 32'h0);
    expect_pc("R6", 32'h0010_0FFE);
    chk("R8", "rd zero link_we", {31'd0, we}, 32'd0);
    // R7 JALR odd sum cleared, negative offset
    apply(32'h6000, mk_jr(12'hFFF, 5'd5), 32'h0000_2000, 32'h0);
    expect_pc("R7", 32'h0000_1FFE);
    // R9 other opcode ignores operands
    apply(32'h7000, 32'hFFFF_F0B3, 32'h1, 32'h1);
    expect_pc("R9", 32'h7004);

    for (int i = 0; i < 4000; i++) begin
      logic [31:0] w, x, y, p;
      int sel;
      w = $urandom; x = $urandom; y = $urandom; p = $urandom & ~32'd3;
      sel = $urandom_range(0, 4);
      case (sel)
        0, 1: w[6:0] = 7'b1100011;
        2: w[6:0] = 7'b1101111;
        3: w[6:0] = 7'b1100111;
        default: if (w[6:0] == 7'b1100011 || w[6:0] == 7'b1101111 || w[6:0] == 7'b1100111) w[6:0] = 7'b0110011;
      endcase
      case ($urandom_range(0, 3))
        0: y = x;
        1: begin x[31] = ~y[31]; end
        default: ;
      endcase
      apply(p, w, x, y);
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule